// File: doc/BRIEF.md
# Dual-Bank Prioritised Interrupt Controller

This block collects 32 interrupt request lines and presents them to a processor as two interrupt outputs, a normal request (`irq_out`) and a fast request (`fiq_out`). Every source first passes through a shared conditioning stage. A polarity bit can invert it, and a capture-mode bit chooses whether the source follows its input level or holds an assertion until software acknowledges it. The conditioned set then enters two identical banks. Each bank applies its own enable mask and its own priority ceiling, and raises its output while any source survives both filters.

Software reaches the block over a plain 32-bit register bus with separate read and write strobes and a 10-bit byte address. Read data is combinational: it is valid in the same cycle as the read strobe. The usual flow is as follows. The handler reads the bank's pending word. While that word is nonzero, it reads the winner register to find which source to serve. A read of the bank's acknowledge address drops that bank's held captures at the following clock edge. The banks share one priority table, which holds a 4-bit level per source. Level 0 is the most urgent.

Register map (byte offsets). The normal bank uses 0x000 to 0x02C and the fast bank uses 0x100 to 0x12C, with the same layout relative to the bank base:

| Offset | Register |
|---|---|
| +0x00 | pending |
| +0x04 | raw |
| +0x08 | enable-set |
| +0x0C | enable-clear |
| +0x20 | winner |
| +0x28 | acknowledge |
| +0x2C | ceiling |

Shared registers: polarity at 0x200, capture mode at 0x204, and the priority table at 0x300 + 4·n for source n.

Top module: `dual_bank_intc`

## Requirements
- R1: After reset, both enable masks read 0, both ceilings read 0xF, polarity reads 0xFFFFFFFF, capture mode reads 0, every priority reads 0, and both outputs are low.
- R2: A write to enable-set (bank +0x08) sets the mask bits where the write data has ones. A write to enable-clear (+0x0C) clears the mask bits where the data has ones. Zero bits leave the mask unchanged. Reading +0x08 returns the mask.
- R3: Polarity bit n = 1 passes source n unchanged. Polarity bit n = 0 inverts it.
- R4: The raw word (+0x04) shows the conditioned sources regardless of mask and ceiling. A level-mode source follows its input in the same cycle.
- R5: With capture bit n = 1, an assertion of source n, even a single cycle long, stays visible in raw and pending until that bank's acknowledge is read. An acknowledge of one bank does not affect the other.
- R6: Pending (+0x00) equals raw AND mask AND (priority ≤ ceiling). Each output is high exactly while its bank's pending word is nonzero.
- R7: The winner register (+0x20) returns the number of the pending source with the numerically smallest priority, picking the lowest number on a tie. It returns 0 when nothing is pending.
- R8: Sources whose priority exceeds the bank ceiling (+0x2C, 4 bits) are removed from pending, from the winner choice and from the output.
- R9: The priority of source n is written and read at 0x300 + 4·n, in data bits [3:0].
- R10: The two banks keep separate masks and ceilings. A write to one bank leaves the other bank unchanged.
- R11: An acknowledge read while a capture-mode source is still asserted leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_in | input | 32 | Interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; acknowledges on the acknowledge address |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq_out | output | 1 | Normal-bank interrupt request |
| fiq_out | output | 1 | Fast-bank interrupt request |

## Verification
Read data and both outputs are combinational, so the value of a register or an output is due in the same cycle as the stimulus. A register write or an acknowledge takes effect at the next rising edge, and a capture takes hold at the first rising edge that sees the source asserted. The directed tasks change inputs on the falling edge and sample 1 ns later. Every bus access spans exactly one rising edge, and each read of a result comes after the edge that commits the effect it checks.

// File: rtl/intc_pkg.sv
package intc_pkg;
    parameter int unsigned NSRC_DEF = 32;
    parameter int unsigned PRIO_W   = 4;
    parameter int unsigned DATA_W   = 32;
    parameter int unsigned ADDR_W   = 10;
    parameter int unsigned NBANK    = 2;

    // Register offsets inside one bank (address bits [7:0])
    localparam logic [7:0] OFS_PEND  = 8'h00;
    localparam logic [7:0] OFS_RAW   = 8'h04;
    localparam logic [7:0] OFS_ENSET = 8'h08;
    localparam logic [7:0] OFS_ENCLR = 8'h0C;
    localparam logic [7:0] OFS_WIN   = 8'h20;
    localparam logic [7:0] OFS_ACK   = 8'h28;
    localparam logic [7:0] OFS_CEIL  = 8'h2C;

    // Shared registers (address bit 9 set, bit 8 clear)
    localparam logic [7:0] OFS_POL   = 8'h00;
    localparam logic [7:0] OFS_MODE  = 8'h04;

    typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intc_cond.sv
module intc_cond #(
    parameter int unsigned NSRC = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] cond_i,
    input  logic [NSRC-1:0] capture_i,
    input  logic            ack_i,
    output logic [NSRC-1:0] raw_o
);
    logic [NSRC-1:0] hold_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_q <= '0;
        else if (ack_i)
            hold_q <= cond_i & capture_i;
        else
            hold_q <= (hold_q | cond_i) & capture_i;
    end

    assign raw_o = cond_i | (hold_q & capture_i);
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 4,
    localparam int unsigned IDW = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]         req_i,
    input  logic [NSRC-1:0][PW-1:0] prio_i,
    input  logic [PW-1:0]           ceil_i,
    output logic [NSRC-1:0]         pend_o,
    output logic [IDW-1:0]          win_o
);
    logic [PW-1:0] best;
    logic          found;

    // Walk from the top index down so that "<=" leaves the lowest index on ties.
    always_comb begin
        pend_o = '0;
        win_o  = '0;
        best   = '1;
        found  = 1'b0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i] && (prio_i[i] <= ceil_i)) begin
                pend_o[i] = 1'b1;
                if (!found || (prio_i[i] <= best)) begin
                    best  = prio_i[i];
                    win_o = IDW'(i);
                    found = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/intc_bank.sv
module intc_bank #(
    parameter int unsigned NSRC = 32,
    parameter int unsigned PW   = 4,
    parameter int unsigned DW   = 32,
    localparam int unsigned IDW = $clog2(NSRC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_set_i,
    input  logic                    en_clr_i,
    input  logic                    ceil_wr_i,
    input  logic [DW-1:0]           wdata_i,
    input  logic [NSRC-1:0]         raw_i,
    input  logic [NSRC-1:0][PW-1:0] prio_i,
    output logic [NSRC-1:0]         en_o,
    output logic [PW-1:0]           ceil_o,
    output logic [NSRC-1:0]         pend_o,
    output logic [IDW-1:0]          win_o,
    output logic                    int_o
);
    logic [NSRC-1:0] en_q;
    logic [PW-1:0]   ceil_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            ceil_q <= '1;
        end else begin
            if (en_set_i)  en_q   <= en_q | wdata_i[NSRC-1:0];
            if (en_clr_i)  en_q   <= en_q & ~wdata_i[NSRC-1:0];
            if (ceil_wr_i) ceil_q <= wdata_i[PW-1:0];
        end
    end

    intc_arb #(.NSRC(NSRC), .PW(PW)) u_arb (
        .req_i  (raw_i & en_q),
        .prio_i (prio_i),
        .ceil_i (ceil_q),
        .pend_o (pend_o),
        .win_o  (win_o)
    );

    assign en_o   = en_q;
    assign ceil_o = ceil_q;
    assign int_o  = |pend_o;
endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import intc_pkg::*;
#(
    parameter int unsigned NSRC = NSRC_DEF,
    parameter int unsigned PW   = PRIO_W,
    parameter int unsigned DW   = DATA_W,
    parameter int unsigned AW   = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [31:0]   src_in,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [9:0]    bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic          irq_out,
    output logic          fiq_out
);
    localparam int unsigned IDW = $clog2(NSRC);

    logic [NSRC-1:0]         pol_q;
    logic [NSRC-1:0]         mode_q;
    logic [NSRC-1:0][PW-1:0] prio_q;
    logic [NSRC-1:0]         cond;

    logic [NSRC-1:0] bank_en   [NBANK];
    logic [NSRC-1:0] bank_raw  [NBANK];
    logic [NSRC-1:0] bank_pend [NBANK];
    logic [IDW-1:0]  bank_win  [NBANK];
    logic [PW-1:0]   bank_ceil [NBANK];
    logic [NBANK-1:0] bank_int;

    logic            shared_sel;
    logic            prio_sel;
    logic [IDW-1:0]  pidx;

    assign shared_sel = bus_addr[9] & ~bus_addr[8];
    assign prio_sel   = bus_addr[9] & bus_addr[8] & ~bus_addr[7];
    assign pidx       = bus_addr[2 +: IDW];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_q  <= '1;
            mode_q <= '0;
            prio_q <= '0;
        end else if (bus_wr) begin
            if (shared_sel && bus_addr[7:0] == OFS_POL)  pol_q  <= bus_wdata[NSRC-1:0];
            if (shared_sel && bus_addr[7:0] == OFS_MODE) mode_q <= bus_wdata[NSRC-1:0];
            if (prio_sel) prio_q[pidx] <= bus_wdata[PW-1:0];
        end
    end

    assign cond = src_in[NSRC-1:0] ~^ pol_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic BSEL = 1'(b);
        logic hit;
        assign hit = ~bus_addr[9] & (bus_addr[8] == BSEL);

        intc_cond #(.NSRC(NSRC)) u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .cond_i    (cond),
            .capture_i (mode_q),
            .ack_i     (bus_rd && hit && bus_addr[7:0] == OFS_ACK),
            .raw_o     (bank_raw[b])
        );

        intc_bank #(.NSRC(NSRC), .PW(PW), .DW(DW)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .en_set_i  (bus_wr && hit && bus_addr[7:0] == OFS_ENSET),
            .en_clr_i  (bus_wr && hit && bus_addr[7:0] == OFS_ENCLR),
            .ceil_wr_i (bus_wr && hit && bus_addr[7:0] == OFS_CEIL),
            .wdata_i   (bus_wdata),
            .raw_i     (bank_raw[b]),
            .prio_i    (prio_q),
            .en_o      (bank_en[b]),
            .ceil_o    (bank_ceil[b]),
            .pend_o    (bank_pend[b]),
            .win_o     (bank_win[b]),
            .int_o     (bank_int[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (!bus_addr[9]) begin
            unique case (bus_addr[7:0])
                OFS_PEND:  bus_rdata = DW'(bank_pend[bus_addr[8]]);
                OFS_RAW:   bus_rdata = DW'(bank_raw[bus_addr[8]]);
                OFS_ENSET: bus_rdata = DW'(bank_en[bus_addr[8]]);
                OFS_WIN:   bus_rdata = DW'(bank_win[bus_addr[8]]);
                OFS_CEIL:  bus_rdata = DW'(bank_ceil[bus_addr[8]]);
                default:   bus_rdata = '0;
            endcase
        end else if (shared_sel) begin
            if (bus_addr[7:0] == OFS_POL)  bus_rdata = DW'(pol_q);
            if (bus_addr[7:0] == OFS_MODE) bus_rdata = DW'(mode_q);
        end else if (prio_sel) begin
            bus_rdata = DW'(prio_q[pidx]);
        end
    end

    assign irq_out = bank_int[0];
    assign fiq_out = bank_int[1];
endmodule

// File: rtl/intc_checker.sv
module intc_checker #(
    parameter int unsigned NSRC = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_wr,
    input logic            bus_rd,
    input logic [9:0]      bus_addr,
    input logic [31:0]     bus_wdata,
    input logic [31:0]     bus_rdata,
    input logic            irq_out,
    input logic            fiq_out,
    input logic [NSRC-1:0] irq_en,
    input logic [NSRC-1:0] fiq_en,
    input logic [NSRC-1:0] irq_raw,
    input logic [NSRC-1:0] mode
);
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_out && !fiq_out && irq_en == '0 && fiq_en == '0));

    p_en_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 10'h008) |=>
            ((irq_en & NSRC'($past(bus_wdata))) == NSRC'($past(bus_wdata))));

    p_en_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 10'h00C) |=> ((irq_en & NSRC'($past(bus_wdata))) == '0));

    p_capture_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && !(bus_rd && bus_addr == 10'h028)) |=>
            (($past(irq_raw & mode) & ~irq_raw) == '0));

    p_irq_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 10'h000) |-> ((bus_rdata != '0) == irq_out));

    p_fiq_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 10'h100) |-> ((bus_rdata != '0) == fiq_out));

    p_win_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 10'h020 && !irq_out) |-> (bus_rdata == '0));

    p_bank_apart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[9:8] == 2'b00) |=> $stable(fiq_en));
endmodule

bind dual_bank_intc intc_checker #(.NSRC(NSRC)) u_intc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .fiq_out   (fiq_out),
    .irq_en    (bank_en[0]),
    .fiq_en    (bank_en[1]),
    .irq_raw   (bank_raw[0]),
    .mode      (mode_q)
);

// File: tb/test_dual_bank_intc.sv
`timescale 1ns/1ps
module test_dual_bank_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic        fiq_out;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    dual_bank_intc i_dual_bank_intc (
        .clk(clk), .rst_n(rst_n), .src_in(src_in),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic set_src(input logic [31:0] v);
        @(negedge clk);
        src_in = v;
        #1;
    endtask

    task automatic t_reset();
        rd_chk("R1 irq mask", 10'h008, 32'h0);
        rd_chk("R1 fiq mask", 10'h108, 32'h0);
        rd_chk("R1 irq ceiling", 10'h02C, 32'hF);
        rd_chk("R1 fiq ceiling", 10'h12C, 32'hF);
        rd_chk("R1 polarity", 10'h200, 32'hFFFF_FFFF);
        rd_chk("R1 capture", 10'h204, 32'h0);
        rd_chk("R1 prio31", 10'h37C, 32'h0);
        check("R1 outputs", {30'b0, irq_out, fiq_out}, 32'h0);
    endtask

    task automatic t_mask();
        wr(10'h008, 32'h0000_00F0);
        rd_chk("R2 set", 10'h008, 32'h0000_00F0);
        wr(10'h00C, 32'h0000_0030);
        rd_chk("R2 clear", 10'h008, 32'h0000_00C0);
        rd_chk("R10 fiq mask untouched", 10'h108, 32'h0);
        wr(10'h12C, 32'h3);
        rd_chk("R10 irq ceiling untouched", 10'h02C, 32'hF);
        wr(10'h12C, 32'hF);
        wr(10'h00C, 32'hFFFF_FFFF);
    endtask

    task automatic t_level();
        set_src(32'h20);
        rd_chk("R4 raw level", 10'h004, 32'h20);
        rd_chk("R6 masked pend", 10'h000, 32'h0);
        check("R6 irq low when masked", {31'b0, irq_out}, 32'h0);
        wr(10'h008, 32'h20);
        rd_chk("R6 pend", 10'h000, 32'h20);
        check("R6 irq high", {31'b0, irq_out}, 32'h1);
        check("R10 fiq low", {31'b0, fiq_out}, 32'h0);
        rd_chk("R7 winner", 10'h020, 32'd5);
        set_src(32'h0);
        check("R4 irq follows level", {31'b0, irq_out}, 32'h0);
        rd_chk("R7 winner idle", 10'h020, 32'h0);
        wr(10'h00C, 32'hFFFF_FFFF);
    endtask

    task automatic t_polarity();
        wr(10'h200, ~32'h8);
        rd_chk("R3 inverted raw", 10'h004, 32'h8);
        set_src(32'h8);
        rd_chk("R3 inverted raw low", 10'h004, 32'h0);
        set_src(32'h0);
        wr(10'h200, 32'hFFFF_FFFF);
        rd_chk("R3 pass raw", 10'h004, 32'h0);
    endtask

    task automatic t_priority();
        wr(10'h008, 32'hFFFF_FFFF);
        wr(10'h308, 32'h3);
        wr(10'h31C, 32'h1);
        wr(10'h324, 32'h1);
        set_src(32'h0000_0284);
        rd_chk("R7 tie lowest", 10'h020, 32'd7);
        wr(10'h31C, 32'h2);
        rd_chk("R9 prio readback", 10'h31C, 32'h2);
        rd_chk("R7 best level", 10'h020, 32'd9);
        wr(10'h02C, 32'h0);
        rd_chk("R8 all filtered", 10'h000, 32'h0);
        check("R8 irq low", {31'b0, irq_out}, 32'h0);
        rd_chk("R8 winner none", 10'h020, 32'h0);
        wr(10'h02C, 32'h1);
        rd_chk("R8 partial", 10'h000, 32'h200);
        rd_chk("R8 winner", 10'h020, 32'd9);
        set_src(32'h0);
        wr(10'h02C, 32'hF);
        wr(10'h308, 32'h0);
        wr(10'h31C, 32'h0);
        wr(10'h324, 32'h0);
        wr(10'h00C, 32'hFFFF_FFFF);
    endtask

    task automatic t_capture();
        wr(10'h204, 32'h10);
        wr(10'h008, 32'h10);
        wr(10'h108, 32'h10);
        @(negedge clk); src_in = 32'h10;
        @(negedge clk); src_in = 32'h0;
        #1;
        rd_chk("R5 irq held", 10'h004, 32'h10);
        rd_chk("R5 fiq held", 10'h104, 32'h10);
        check("R5 both out", {30'b0, irq_out, fiq_out}, 32'h3);
        rd_chk("R5 irq ack read", 10'h028, 32'h0);
        rd_chk("R5 irq cleared", 10'h004, 32'h0);
        rd_chk("R5 fiq kept", 10'h104, 32'h10);
        check("R5 outs after irq ack", {30'b0, irq_out, fiq_out}, 32'h1);
        rd_chk("R5 fiq ack read", 10'h128, 32'h0);
        check("R5 fiq out cleared", {31'b0, fiq_out}, 32'h0);
        set_src(32'h10);
        rd_chk("R11 ack read while high", 10'h028, 32'h0);
        rd_chk("R11 still pending", 10'h000, 32'h10);
        set_src(32'h0);
        rd_chk("R11 held after drop", 10'h000, 32'h10);
        rd_chk("R11 final ack", 10'h028, 32'h0);
        rd_chk("R11 released", 10'h000, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_mask();
        t_level();
        t_polarity();
        t_priority();
        t_capture();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule